// File: doc/BRIEF.md
# Split-Tenure System Bus Arbiter

This block arbitrates a shared system bus whose address and data phases are owned separately. Each master has a request line, an address-bus grant and a data-bus grant. The arbiter watches the shared wired-OR address-busy and data-busy lines, the transfer-start strobe, the slave's address acknowledge with its retry qualifier, and the transfer acknowledge. From these it tracks when each tenure begins and ends, and it hands out the next grant.

Address ownership rotates round-robin among requesters. When an address tenure is acknowledged without retry, its master is placed in a two-entry pending queue. Data-bus grants are issued from that queue in acknowledge order. A retried tenure queues nothing and leaves the rotation unchanged, so the same master can be granted again.

Top module: `split_bus_arbiter`

## Requirements
- R1: After reset both grant vectors are all zero and no data tenure is pending. The reset input is asynchronous and active low, and its release is synchronised inside the block.
- R2: An address grant is issued only at a clock edge where the address-busy line is sampled low and some request is high. It is visible after that edge.
- R3: The address-grant search starts at the master after the last one whose address tenure was acknowledged without retry. After reset the search starts at master 0.
- R4: If the granted master drops its request before transfer-start is sampled, the address grant is withdrawn at the next edge.
- R5: The address grant is removed at the edge where transfer-start is sampled. The tenure then lasts until an address acknowledge is sampled.
- R6: An address acknowledge sampled with retry high queues no data tenure and leaves the round-robin position unchanged, so a master that is still requesting can be granted again.
- R7: Data grants go to masters whose address tenures were acknowledged without retry, in acknowledge order. A data grant is issued only at an edge where data-busy is sampled low.
- R8: A data grant stays unchanged until a transfer acknowledge is sampled. It is removed at that edge.
- R9: At most 2 data tenures are pending. While the queue is full, no new address grant is issued.
- R10: Each grant vector has at most one bit set. Bit i belongs to master i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_MASTERS | Per-master bus request |
| abus_grant | output | NUM_MASTERS | Per-master address-bus grant, one-hot or zero |
| dbus_grant | output | NUM_MASTERS | Per-master data-bus grant, one-hot or zero |
| abus_busy | input | 1 | Wired-OR address-bus-busy |
| xfer_start | input | 1 | Transfer-start strobe from the address owner |
| addr_ack | input | 1 | Address acknowledge from the slave |
| addr_retry | input | 1 | Retry qualifier, sampled with addr_ack |
| dbus_busy | input | 1 | Wired-OR data-bus-busy |
| data_ack | input | 1 | Transfer acknowledge ending the data tenure |

## Verification
The assertions assume that masters follow the bus protocol:
- transfer-start comes only from the master that holds the address grant;
- address acknowledge arrives only during an address tenure;
- the busy lines are raised by the new owner and released after its acknowledge.

The bench keeps to these rules. Each directed task plays one master's handshake at a time and raises a busy line only when it takes ownership. The one deliberate clash is a busy line held high by another master while a request waits.

// File: rtl/split_bus_pkg.sv
package split_bus_pkg;
  typedef enum logic [1:0] {
    A_IDLE    = 2'd0,
    A_GRANT   = 2'd1,
    A_TENURE  = 2'd2,
    A_RELEASE = 2'd3
  } addr_state_e;

  typedef enum logic [1:0] {
    D_IDLE    = 2'd0,
    D_GRANT   = 2'd1,
    D_RELEASE = 2'd2
  } data_state_e;
endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last_idx,
  output logic          any,
  output logic [IW-1:0] pick_idx
);
  int cand;

  // scan from farthest to nearest so the nearest requester wins
  always_comb begin
    any      = 1'b0;
    pick_idx = last_idx;
    cand     = 0;
    for (int k = N; k >= 1; k--) begin
      cand = (int'(last_idx) + k) % N;
      if (req[cand]) begin
        any      = 1'b1;
        pick_idx = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/tenure_queue.sv
module tenure_queue #(
  parameter int DEPTH = 2,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_idx,
  input  logic         pop,
  output logic [W-1:0] head_idx,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          push_ok, pop_ok;

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign head_idx = slots[rd_ptr];

  always_comb begin
    wr_ptr_n = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    rd_ptr_n = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_n = cnt + 1'b1;
      2'b01:   cnt_n = cnt - 1'b1;
      default: cnt_n = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr_n;
      if (pop_ok)  rd_ptr <= rd_ptr_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) slots[wr_ptr] <= push_idx;
  end
endmodule

// File: rtl/addr_tenure_ctrl.sv
module addr_tenure_ctrl
  import split_bus_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          abus_busy,
  input  logic          xfer_start,
  input  logic          addr_ack,
  input  logic          addr_retry,
  input  logic          room,
  output logic [N-1:0]  grant,
  output logic          push,
  output logic [IW-1:0] push_idx
);
  addr_state_e   state, state_n;
  logic [N-1:0]  grant_n;
  logic [IW-1:0] owner, owner_n, last, last_n, pick;
  logic          any;

  rr_picker #(.N(N), .IW(IW)) u_pick (
    .req      (req),
    .last_idx (last),
    .any      (any),
    .pick_idx (pick)
  );

  assign push_idx = owner;

  always_comb begin
    state_n = state;
    grant_n = grant;
    owner_n = owner;
    last_n  = last;
    push    = 1'b0;
    case (state)
      A_IDLE, A_RELEASE: begin
        if (!abus_busy) begin
          if (any && room) begin
            grant_n = {{(N-1){1'b0}}, 1'b1} << pick;
            owner_n = pick;
            state_n = A_GRANT;
          end else begin
            state_n = A_IDLE;
          end
        end
      end
      A_GRANT: begin
        if (xfer_start) begin
          grant_n = '0;
          state_n = A_TENURE;
        end else if (!req[owner]) begin
          grant_n = '0;
          state_n = A_IDLE;
        end
      end
      A_TENURE: begin
        if (addr_ack) begin
          state_n = A_RELEASE;
          if (!addr_retry) begin
            push   = 1'b1;
            last_n = owner;
          end
        end
      end
      default: state_n = A_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= A_IDLE;
      grant <= '0;
      owner <= '0;
      last  <= IW'(N - 1);
    end else begin
      state <= state_n;
      grant <= grant_n;
      owner <= owner_n;
      last  <= last_n;
    end
  end
endmodule

// File: rtl/data_tenure_ctrl.sv
module data_tenure_ctrl
  import split_bus_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbus_busy,
  input  logic          data_ack,
  input  logic          q_empty,
  input  logic [IW-1:0] head_idx,
  output logic [N-1:0]  grant,
  output logic          pop
);
  data_state_e  state, state_n;
  logic [N-1:0] grant_n;

  always_comb begin
    state_n = state;
    grant_n = grant;
    pop     = 1'b0;
    case (state)
      D_IDLE, D_RELEASE: begin
        if (!dbus_busy) begin
          if (!q_empty) begin
            grant_n = {{(N-1){1'b0}}, 1'b1} << head_idx;
            state_n = D_GRANT;
          end else begin
            state_n = D_IDLE;
          end
        end
      end
      D_GRANT: begin
        if (data_ack) begin
          grant_n = '0;
          pop     = 1'b1;
          state_n = D_RELEASE;
        end
      end
      default: state_n = D_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= D_IDLE;
      grant <= '0;
    end else begin
      state <= state_n;
      grant <= grant_n;
    end
  end
endmodule

// File: rtl/split_bus_arbiter.sv
module split_bus_arbiter #(
  parameter int NUM_MASTERS = 4,
  parameter int QUEUE_DEPTH = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  output logic [NUM_MASTERS-1:0] abus_grant,
  output logic [NUM_MASTERS-1:0] dbus_grant,
  input  logic                   abus_busy,
  input  logic                   xfer_start,
  input  logic                   addr_ack,
  input  logic                   addr_retry,
  input  logic                   dbus_busy,
  input  logic                   data_ack
);
  localparam int IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

  logic          rst_meta_n, rst_sync_n;
  logic          q_push, q_pop, q_empty, q_full;
  logic [IW-1:0] q_in_idx, q_head_idx;

  // asynchronous assertion, release aligned to the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  addr_tenure_ctrl #(.N(NUM_MASTERS), .IW(IW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req        (req),
    .abus_busy  (abus_busy),
    .xfer_start (xfer_start),
    .addr_ack   (addr_ack),
    .addr_retry (addr_retry),
    .room       (!q_full),
    .grant      (abus_grant),
    .push       (q_push),
    .push_idx   (q_in_idx)
  );

  tenure_queue #(.DEPTH(QUEUE_DEPTH), .W(IW)) u_queue (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (q_push),
    .push_idx (q_in_idx),
    .pop      (q_pop),
    .head_idx (q_head_idx),
    .empty    (q_empty),
    .full     (q_full)
  );

  data_tenure_ctrl #(.N(NUM_MASTERS), .IW(IW)) u_data (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .dbus_busy (dbus_busy),
    .data_ack  (data_ack),
    .q_empty   (q_empty),
    .head_idx  (q_head_idx),
    .grant     (dbus_grant),
    .pop       (q_pop)
  );
endmodule

// File: rtl/split_bus_arbiter_checker.sv
module split_bus_arbiter_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] abus_grant,
  input logic [N-1:0] dbus_grant,
  input logic         abus_busy,
  input logic         xfer_start,
  input logic         dbus_busy,
  input logic         data_ack,
  input logic         q_full
);
  assert_abus_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(abus_grant));

  assert_dbus_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dbus_grant));

  assert_abus_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|abus_grant) |-> !$past(abus_busy));

  assert_withdraw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|abus_grant) && ((abus_grant & req) == '0) && !xfer_start) |=> (abus_grant == '0));

  assert_start_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|abus_grant) && xfer_start) |=> (abus_grant == '0));

  assert_dbus_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dbus_grant) |-> !$past(dbus_busy));

  assert_dbus_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dbus_grant) && !data_ack) |=> $stable(dbus_grant));

  assert_dbus_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dbus_grant) && data_ack) |=> (dbus_grant == '0));

  assert_full_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|abus_grant) |-> !$past(q_full));
endmodule

bind split_bus_arbiter split_bus_arbiter_checker #(.N(NUM_MASTERS)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .abus_grant (abus_grant),
  .dbus_grant (dbus_grant),
  .abus_busy  (abus_busy),
  .xfer_start (xfer_start),
  .dbus_busy  (dbus_busy),
  .data_ack   (data_ack),
  .q_full     (q_full)
);

// File: tb/split_bus_arbiter_test.sv
`timescale 1ns/1ps
module split_bus_arbiter_test;
  localparam int N = 4;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req;
  logic [N-1:0] abus_grant, dbus_grant;
  logic         abus_busy, xfer_start, addr_ack, addr_retry, dbus_busy, data_ack;
  int           checks = 0;
  int           failures = 0;
  bit           done = 0;

  split_bus_arbiter #(.NUM_MASTERS(N), .QUEUE_DEPTH(2)) uut (
    .clk(clk), .rst_n(rst_n), .req(req),
    .abus_grant(abus_grant), .dbus_grant(dbus_grant),
    .abus_busy(abus_busy), .xfer_start(xfer_start),
    .addr_ack(addr_ack), .addr_retry(addr_retry),
    .dbus_busy(dbus_busy), .data_ack(data_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // the granted master m runs one address tenure
  task automatic addr_tenure(input int m, input bit retry, input bit drop);
    check("R5 grant before start", abus_grant, 4'b1 << m);
    xfer_start = 1'b1; abus_busy = 1'b1;
    step();
    check("R5 grant removed on start", abus_grant, '0);
    xfer_start = 1'b0; addr_ack = 1'b1; addr_retry = retry;
    step();
    addr_ack = 1'b0; addr_retry = 1'b0; abus_busy = 1'b0;
    if (drop) req[m] = 1'b0;
  endtask

  task automatic data_tenure(input int m);
    check("R7 data grant owner", dbus_grant, 4'b1 << m);
    dbus_busy = 1'b1;
    step();
    check("R8 data grant held", dbus_grant, 4'b1 << m);
    data_ack = 1'b1;
    step();
    check("R8 data grant dropped on ack", dbus_grant, '0);
    data_ack = 1'b0; dbus_busy = 1'b0;
  endtask

  task automatic test_reset();
    rst_n = 1'b0; req = '0; abus_busy = 0; xfer_start = 0;
    addr_ack = 0; addr_retry = 0; dbus_busy = 0; data_ack = 0;
    repeat (3) step();
    check("R1 abus grant in reset", abus_grant, '0);
    check("R1 dbus grant in reset", dbus_grant, '0);
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 dbus grant idle after reset", dbus_grant, '0);
  endtask

  task automatic test_basic();
    req[0] = 1'b1;
    step();
    check("R3 first grant to master 0", abus_grant, 4'b0001);
    addr_tenure(0, 1'b0, 1'b1);
    step();
    check("R7 data grant after ack", dbus_grant, 4'b0001);
    check("R10 no address grant idle", abus_grant, '0);
    data_tenure(0);
    step();
  endtask

  task automatic test_busy_and_withdraw();
    req[1] = 1'b1; abus_busy = 1'b1;
    step();
    step();
    check("R2 no grant while busy", abus_grant, '0);
    abus_busy = 1'b0;
    step();
    check("R2 grant after busy released", abus_grant, 4'b0010);
    req[1] = 1'b0;
    step();
    check("R4 grant withdrawn", abus_grant, '0);
  endtask

  task automatic test_rr_and_full();
    req = 4'b1101;
    step();
    check("R3 rotation picks master 2", abus_grant, 4'b0100);
    addr_tenure(2, 1'b0, 1'b1);
    step();
    check("R3 rotation picks master 3", abus_grant, 4'b1000);
    addr_tenure(3, 1'b0, 1'b1);
    step();
    check("R9 no grant while queue full", abus_grant, '0);
    check("R7 oldest ack served first", dbus_grant, 4'b0100);
    data_tenure(2);
    check("R9 still blocked at pop edge", abus_grant, '0);
    step();
    check("R9 grant after queue drains", abus_grant, 4'b0001);
    check("R7 second ack served next", dbus_grant, 4'b1000);
    data_tenure(3);
    step();
  endtask

  task automatic test_retry();
    req[1] = 1'b1;
    check("R6 master 0 holds grant", abus_grant, 4'b0001);
    addr_tenure(0, 1'b1, 1'b0);
    step();
    check("R6 retried master re-granted", abus_grant, 4'b0001);
    check("R6 retry queues no data", dbus_grant, '0);
    addr_tenure(0, 1'b0, 1'b1);
    step();
    check("R3 rotation moves on to master 1", abus_grant, 4'b0010);
    check("R7 data grant after clean ack", dbus_grant, 4'b0001);
    check("R10 grant vectors one-hot", N'($countones(abus_grant) + $countones(dbus_grant)), N'(2));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_basic();
    test_busy_and_withdraw();
    test_rr_and_full();
    test_retry();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule